// File: doc/BRIEF.md
# Split-Tenure Bus Master Sequencer

This block sequences the control lines of a bus master on a bus where the address phase and the data phase are separate tenures. Each tenure has its own busy line and its own ownership handshake. A local requester raises `req_i` and holds it. The sequencer waits until no other master holds the address busy line. It then opens an address tenure, marked by a one-clock start strobe, and holds address-busy low until the slave acknowledges the address. When the acknowledge is clean, the sequencer waits for a data grant while no other master holds data-busy. It then holds data-busy low until the transfer acknowledge arrives and signals completion to the requester.

Both busy lines are shared. Each is modelled as a value and an output enable. When a tenure ends, its busy line is driven high for one clock and then released. A retry that arrives together with the address acknowledge cancels the data phase and counts the retry. The sequencer then competes for the address bus again from idle for as long as the request stays raised. All bus-side control signals are active-low.

Top module: `split_bus_master`

## Requirements
- R1: While and after reset, `start_n_o`=1, `abusy_oe_o`=0, `dbusy_oe_o`=0, `done_o`=0 and `retry_cnt_o`=0.
- R2: An address tenure begins on the clock after an edge at which all of these hold: the sequencer is idle, no data tenure is outstanding, `req_i`=1 and `abusy_n_i`=1. While `abusy_n_i`=0, no tenure begins.
- R3: `start_n_o` is low for exactly one clock, namely the first clock of each address tenure.
- R4: From its first clock, the address tenure drives `abusy_n_o`=0 with `abusy_oe_o`=1 until an edge samples `addr_ack_n_i`=0. After that edge, `abusy_n_o`=1 is driven for one clock, and then `abusy_oe_o` falls.
- R5: When `addr_retry_n_i`=0 is sampled at the same edge as `addr_ack_n_i`=0, no data tenure follows. `retry_cnt_o` increments, the address release of R4 still happens, and a new address tenure is arbitrated from idle while `req_i` stays 1. A retry sampled without an acknowledge has no effect.
- R6: After a clean address acknowledge, the data tenure begins on the clock after an edge that samples both `dgrant_n_i`=0 and `dbusy_n_i`=1. While `dbusy_n_i`=0, no data tenure begins.
- R7: The data tenure drives `dbusy_n_o`=0 with `dbusy_oe_o`=1 until an edge samples `xfer_ack_n_i`=0. It then drives `dbusy_n_o`=1 for one clock, and then `dbusy_oe_o` falls.
- R8: `done_o` is high for exactly one clock, the clock in which data-busy is being driven high during its release.
- R9: `retry_cnt_o` is cumulative since reset and saturates at 2^CNT_W-1.
- R10: `abusy_oe_o` and `dbusy_oe_o` are never high in the same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Transfer request, held until done_o |
| done_o | output | 1 | One-clock completion pulse |
| retry_cnt_o | output | CNT_W | Saturating retry count |
| abusy_n_i | input | 1 | Address-busy line as seen from the bus |
| start_n_o | output | 1 | Address tenure start strobe |
| abusy_n_o | output | 1 | Address-busy drive value |
| abusy_oe_o | output | 1 | Address-busy output enable |
| addr_ack_n_i | input | 1 | Slave address acknowledge |
| addr_retry_n_i | input | 1 | Address retry request |
| dgrant_n_i | input | 1 | Data bus grant from arbiter |
| dbusy_n_i | input | 1 | Data-busy line as seen from the bus |
| dbusy_n_o | output | 1 | Data-busy drive value |
| dbusy_oe_o | output | 1 | Data-busy output enable |
| xfer_ack_n_i | input | 1 | Transfer acknowledge |

## Verification
The bench holds each busy line low while a request or grant is pending. A design that ignored either line would open a tenure on top of another master. It drives an acknowledge in the very first address clock, which a design that assumed a minimum tenure length would miss. It also asserts a retry without an acknowledge, which a design that treated retry alone as terminating would count and restart on. Back-to-back retries push the counter past its maximum, so that a wrapping counter shows up as a drop to zero. Every release is compared clock by clock, so a release that tri-states at once or holds the high level for two clocks is flagged.

// File: rtl/sbm_pkg.sv
package sbm_pkg;
  typedef enum logic [1:0] {A_IDLE, A_TEN, A_REL} addr_st_e;
  typedef enum logic [1:0] {D_IDLE, D_WAIT, D_TEN, D_REL} data_st_e;
endpackage

// File: rtl/sbm_addr_fsm.sv
module sbm_addr_fsm
  import sbm_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic go_i,
  input  logic abusy_n_i,
  input  logic addr_ack_n_i,
  input  logic addr_retry_n_i,
  output logic start_n_o,
  output logic abusy_n_o,
  output logic abusy_oe_o,
  output logic arm_o,
  output logic retry_o
);
  addr_st_e st_q, st_d;
  logic first_q;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      A_IDLE: if (go_i && abusy_n_i) st_d = A_TEN;
      A_TEN:  if (!addr_ack_n_i) st_d = A_REL;
      A_REL:  st_d = A_IDLE;
      default: st_d = A_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= A_IDLE;
      first_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      first_q <= (st_q == A_IDLE) && (st_d == A_TEN);
    end
  end

  // retry only counts when it coincides with the acknowledge
  assign arm_o      = (st_q == A_TEN) && !addr_ack_n_i && addr_retry_n_i;
  assign retry_o    = (st_q == A_TEN) && !addr_ack_n_i && !addr_retry_n_i;
  assign start_n_o  = !((st_q == A_TEN) && first_q);
  assign abusy_oe_o = (st_q != A_IDLE);
  assign abusy_n_o  = (st_q != A_TEN);

  // R3
  start_one_clk_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_n_o |=> start_n_o);
  // R3
  start_in_tenure_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_n_o |-> (abusy_oe_o && !abusy_n_o));
  // R2
  no_start_on_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(abusy_oe_o) |-> ($past(abusy_n_i) && $past(go_i)));
  // R4
  addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (abusy_oe_o && !abusy_n_o && addr_ack_n_i) |=> (abusy_oe_o && !abusy_n_o));
  // R4
  addr_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (abusy_oe_o && !abusy_n_o && !addr_ack_n_i) |=> (abusy_oe_o && abusy_n_o));
  // R4
  addr_rel_one_clk_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (abusy_oe_o && abusy_n_o) |=> !abusy_oe_o);
endmodule

// File: rtl/sbm_data_fsm.sv
module sbm_data_fsm
  import sbm_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arm_i,
  input  logic dgrant_n_i,
  input  logic dbusy_n_i,
  input  logic xfer_ack_n_i,
  output logic dbusy_n_o,
  output logic dbusy_oe_o,
  output logic idle_o,
  output logic done_o
);
  data_st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      D_IDLE: if (arm_i) st_d = D_WAIT;
      D_WAIT: if (!dgrant_n_i && dbusy_n_i) st_d = D_TEN;
      D_TEN:  if (!xfer_ack_n_i) st_d = D_REL;
      D_REL:  st_d = D_IDLE;
      default: st_d = D_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= D_IDLE;
    else         st_q <= st_d;
  end

  assign idle_o     = (st_q == D_IDLE);
  assign dbusy_oe_o = (st_q == D_TEN) || (st_q == D_REL);
  assign dbusy_n_o  = (st_q != D_TEN);
  assign done_o     = (st_q == D_REL);

  // R6
  data_grant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dbusy_oe_o) |-> ($past(!dgrant_n_i) && $past(dbusy_n_i)));
  // R7
  data_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dbusy_oe_o && !dbusy_n_o && xfer_ack_n_i) |=> (dbusy_oe_o && !dbusy_n_o));
  // R7
  data_rel_one_clk_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dbusy_oe_o && dbusy_n_o) |=> !dbusy_oe_o);
  // R8
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

// File: rtl/sbm_retry_cnt.sv
module sbm_retry_cnt #(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CntMax = {CNT_W{1'b1}};
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        cnt_q <= '0;
    else if (inc_i && cnt_q != CntMax)  cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  // R5
  cnt_inc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && cnt_q != CntMax) |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1)));
  // R9
  cnt_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == CntMax) |=> (cnt_q == CntMax));
endmodule

// File: rtl/split_bus_master.sv
module split_bus_master #(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  output logic             done_o,
  output logic [CNT_W-1:0] retry_cnt_o,
  input  logic             abusy_n_i,
  output logic             start_n_o,
  output logic             abusy_n_o,
  output logic             abusy_oe_o,
  input  logic             addr_ack_n_i,
  input  logic             addr_retry_n_i,
  input  logic             dgrant_n_i,
  input  logic             dbusy_n_i,
  output logic             dbusy_n_o,
  output logic             dbusy_oe_o,
  input  logic             xfer_ack_n_i
);
  logic arm, retry, d_idle;

  sbm_addr_fsm u_addr (
    .clk_i, .rst_ni,
    .go_i           (req_i && d_idle),
    .abusy_n_i, .addr_ack_n_i, .addr_retry_n_i,
    .start_n_o, .abusy_n_o, .abusy_oe_o,
    .arm_o          (arm),
    .retry_o        (retry)
  );

  sbm_data_fsm u_data (
    .clk_i, .rst_ni,
    .arm_i          (arm),
    .dgrant_n_i, .dbusy_n_i, .xfer_ack_n_i,
    .dbusy_n_o, .dbusy_oe_o,
    .idle_o         (d_idle),
    .done_o
  );

  sbm_retry_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni,
    .inc_i          (retry),
    .cnt_o          (retry_cnt_o)
  );

  // R10
  one_tenure_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(abusy_oe_o && dbusy_oe_o));
endmodule

// File: tb/split_bus_master_bench.sv
module split_bus_master_bench;
  localparam int CW = 4;
  localparam int MAXC = (1 << CW) - 1;

  logic clk = 0, rst_n = 0;
  logic req = 0, abusy_n_i = 1, ack_n = 1, rty_n = 1, gnt_n = 1, dbusy_n_i = 1, ta_n = 1;
  logic done, start_n, ab_n, ab_oe, db_n, db_oe;
  logic [CW-1:0] cnt;

  int checks = 0, fails = 0;
  int m_a = 0, m_d = 0, m_cnt = 0;
  bit m_first = 0;

  always #10 clk = ~clk;

  split_bus_master #(.CNT_W(CW)) u_split_bus_master (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .done_o(done), .retry_cnt_o(cnt),
    .abusy_n_i(abusy_n_i), .start_n_o(start_n), .abusy_n_o(ab_n), .abusy_oe_o(ab_oe),
    .addr_ack_n_i(ack_n), .addr_retry_n_i(rty_n), .dgrant_n_i(gnt_n),
    .dbusy_n_i(dbusy_n_i), .dbusy_n_o(db_n), .dbusy_oe_o(db_oe), .xfer_ack_n_i(ta_n)
  );

  // behavioural reference: phases as integers
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_a <= 0; m_d <= 0; m_first <= 0; m_cnt <= 0;
    end else begin
      m_first <= 0;
      if (m_a == 0 && req && abusy_n_i && m_d == 0) begin m_a <= 1; m_first <= 1; end
      else if (m_a == 1 && !ack_n) begin
        m_a <= 2;
        if (!rty_n) m_cnt <= (m_cnt == MAXC) ? MAXC : m_cnt + 1;
      end else if (m_a == 2) m_a <= 0;
      if (m_a == 1 && !ack_n && rty_n) m_d <= 1;
      else if (m_d == 1 && !gnt_n && dbusy_n_i) m_d <= 2;
      else if (m_d == 2 && !ta_n) m_d <= 3;
      else if (m_d == 3) m_d <= 0;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    chk("R3 start_n", start_n, !(m_a == 1 && m_first));
    chk("R2,R4 abusy_oe", ab_oe, m_a != 0);
    chk("R4 abusy_n", ab_n, m_a != 1);
    chk("R6,R7 dbusy_oe", db_oe, m_d >= 2);
    chk("R7 dbusy_n", db_n, m_d != 2);
    chk("R8 done", done, m_d == 3);
    chk("R5,R9 retry_cnt", cnt, m_cnt);
    chk("R10 exclusive", ab_oe && db_oe, 0);
  end

  task automatic wait_for(input bit addr);
    for (int i = 0; i < 200; i++) begin
      if (addr ? (ab_oe && !ab_n) : (db_oe && !db_n)) return;
      @(negedge clk);
    end
    fails++;
    $display("FAIL R2,R6 tenure never opened (actual 0 expected 1)");
  endtask

  // one transfer; the first n_rty acknowledges carry a retry
  task automatic xfer(input int ext_ab, input int ack_dly, input int n_rty,
                      input bit stray, input int ext_db, input int ta_dly);
    @(negedge clk);
    req = 1;
    if (ext_ab > 0) begin
      abusy_n_i = 0;
      repeat (ext_ab) begin
        @(negedge clk);
        chk("R2 blocked by ext abusy", ab_oe, 0);
      end
      abusy_n_i = 1;
    end
    for (int k = 0; k <= n_rty; k++) begin
      wait_for(1);
      if (stray && ack_dly > 0) begin
        rty_n = 0; @(negedge clk); rty_n = 1;
        repeat (ack_dly - 1) @(negedge clk);
      end else repeat (ack_dly) @(negedge clk);
      ack_n = 0; rty_n = (k < n_rty) ? 0 : 1;
      @(negedge clk);
      ack_n = 1; rty_n = 1;
    end
    gnt_n = 0;
    if (ext_db > 0) begin
      dbusy_n_i = 0;
      repeat (ext_db) begin
        @(negedge clk);
        chk("R6 blocked by ext dbusy", db_oe, 0);
      end
      dbusy_n_i = 1;
    end
    wait_for(0);
    repeat (ta_dly) @(negedge clk);
    ta_n = 0;
    @(negedge clk);
    ta_n = 1; gnt_n = 1;
    chk("R8 done at release", done, 1);
    req = 0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset abusy_oe", ab_oe, 0);
    chk("R1 reset dbusy_oe", db_oe, 0);
    chk("R1 reset start_n", start_n, 1);
    chk("R1 reset done", done, 0);
    chk("R1 reset cnt", cnt, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    xfer(0, 2, 0, 0, 0, 2);   // plain
    xfer(3, 0, 0, 0, 0, 0);   // ext abusy, ack in first clock
    xfer(0, 1, 0, 0, 4, 1);   // ext dbusy
    xfer(0, 1, 1, 0, 0, 1);   // one retry
    xfer(0, 3, 0, 1, 0, 1);   // stray retry without ack
    chk("R5 stray retry ignored", cnt, 1);
    xfer(1, 0, 17, 0, 0, 0);  // drive counter to saturation
    chk("R9 saturated", cnt, MAXC);
    repeat (4) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired (actual running expected finished)");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule